// File: doc/BRIEF.md
# IDE PIO Timing Register Bank

This block is the control and timing register file of a two-channel ATA host that moves data by programmed I/O. Software reaches it through a byte-wide indexed port. It drives an offset on `reg_addr`. Writes take effect at the next clock edge, and reads return the addressed byte combinationally on `reg_rdata`.

The bank has four kinds of register: a control byte, a command-block timing byte, address-setup bytes and data read/write timing bytes. On the primary channel, each drive has its own setup/timing pair. The two drives of the secondary channel share one pair. A scratch byte lets software confirm that the device is present. A read-only configuration byte reports the chip revision and the state of a board strap.

The strobe generator sits outside this block and selects a channel and drive with `sel_chan` and `sel_drive`. The bank answers with the decoded address-setup clock count, the active and recovery counts, and the read-ahead permission for that drive. The address-setup field uses a two-bit code whose order is not monotonic.

Top module: `ide_pio_timing_bank`

## Requirements
- R1: Offsets 0x51 (control), 0x52 (command timing), 0x53/0x54 (primary drive 0 setup/timing), 0x55/0x56 (primary drive 1 setup/timing) and 0x57/0x58 (secondary shared setup/timing) store all eight bits written. A read returns the stored value from the cycle after the write edge onward.
- R2: While reset is active, 0x53 and 0x55 are set to 0xC0 and 0x57 to 0xCC. Offsets 0x51, 0x52, 0x54, 0x56, 0x58 and 0x5B are set to 0x00.
- R3: `setup_clks` decodes bits [7:6] of the selected setup byte as follows: 01 gives 2, 10 gives 3, 00 gives 4 and 11 gives 5.
- R4: `active_clks` is bits [7:4] and `recovery_clks` is bits [3:0] of the selected timing byte. The pair used is 0x53/0x54 for channel 0 drive 0 and 0x55/0x56 for channel 0 drive 1. Either drive on channel 1 uses 0x57/0x58. The outputs follow the selection in the same cycle.
- R5: On channel 0, `readahead_en` is the inverse of control bit 6 for drive 0 and the inverse of control bit 7 for drive 1.
- R6: Control bit 3 is `sec_chan_en`. With it set, `readahead_en` on channel 1 is the inverse of bit 2 of 0x57 for drive 0 and the inverse of bit 3 of 0x57 for drive 1.
- R7: While control bit 3 is clear, any selection on channel 1 holds `readahead_en` low. Channel 0 is not affected.
- R8: Offset 0x5B reads back the last byte written to it.
- R9: Offset 0x50 is read-only. Bits [1:0] give the nonzero `CHIP_REV` parameter, bit 5 gives `alt_base_strap`, and all other bits read 0. Writes to it change nothing.
- R10: Reads of any other offset return 0x00. Writes to such offsets leave every register and every output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, sampled at the clock edge |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| alt_base_strap | input | 1 | Board strap reported in bit 5 of offset 0x50 |
| sel_chan | input | 1 | Selected channel (0 primary, 1 secondary) |
| sel_drive | input | 1 | Selected drive on that channel |
| setup_clks | output | 3 | Decoded address-setup clocks (2 to 5) |
| active_clks | output | 4 | Active count of the selected drive |
| recovery_clks | output | 4 | Recovery count of the selected drive |
| readahead_en | output | 1 | Read-ahead permission for the selected drive |
| sec_chan_en | output | 1 | Secondary channel enabled (control bit 3) |

## Verification
The output path is tested with a different setup code and a different active/recovery nibble pair in every timing slot. A wrong slot choice, or swapped nibbles, therefore shows up as a wrong number. All four setup codes are tried, which exposes a decode that wrongly assumes the codes are ordered. Each read-ahead disable bit is set on its own while the other bits stay clear, so the test can tell which drive each bit gates. The secondary bits are tried both with the channel enabled and with it disabled. Writes to unimplemented offsets and to the configuration byte use all-ones data, and every register and output is read back afterwards.

// File: rtl/ide_tim_pkg.sv
package ide_tim_pkg;

    localparam int REG_W = 8;
    localparam int NSLOT = 9;

    localparam logic [7:0] OFF_CFG  = 8'h50;
    localparam logic [7:0] OFF_CTRL = 8'h51;
    localparam logic [7:0] OFF_CMDT = 8'h52;
    localparam logic [7:0] OFF_SU0  = 8'h53;
    localparam logic [7:0] OFF_RW0  = 8'h54;
    localparam logic [7:0] OFF_SU1  = 8'h55;
    localparam logic [7:0] OFF_RW1  = 8'h56;
    localparam logic [7:0] OFF_SU2  = 8'h57;
    localparam logic [7:0] OFF_RW2  = 8'h58;
    localparam logic [7:0] OFF_SCR  = 8'h5B;

    // slot indices into the writable bank
    localparam int SL_CTRL = 0;
    localparam int SL_CMDT = 1;
    localparam int SL_SU0  = 2;
    localparam int SL_RW0  = 3;
    localparam int SL_SU1  = 4;
    localparam int SL_RW1  = 5;
    localparam int SL_SU2  = 6;
    localparam int SL_RW2  = 7;
    localparam int SL_SCR  = 8;

    // bit positions that the selection logic decodes
    localparam int CTRL_P0_RA_OFF = 6;
    localparam int CTRL_P1_RA_OFF = 7;
    localparam int CTRL_SEC_EN    = 3;
    localparam int SU2_S0_RA_OFF  = 2;
    localparam int SU2_S1_RA_OFF  = 3;
    localparam int CFG_STRAP_BIT  = 5;

    typedef enum logic [1:0] {
        SU_FOUR = 2'b00,
        SU_TWO  = 2'b01,
        SU_THREE = 2'b10,
        SU_FIVE = 2'b11
    } setup_code_e;

    typedef struct packed {
        logic [2:0] setup;
        logic [3:0] active;
        logic [3:0] recovery;
    } drv_timing_t;

    function automatic logic [7:0] slot_offset(input int i);
        case (i)
            SL_CTRL: slot_offset = OFF_CTRL;
            SL_CMDT: slot_offset = OFF_CMDT;
            SL_SU0:  slot_offset = OFF_SU0;
            SL_RW0:  slot_offset = OFF_RW0;
            SL_SU1:  slot_offset = OFF_SU1;
            SL_RW1:  slot_offset = OFF_RW1;
            SL_SU2:  slot_offset = OFF_SU2;
            SL_RW2:  slot_offset = OFF_RW2;
            default: slot_offset = OFF_SCR;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] slot_reset(input int i);
        case (i)
            SL_SU0, SL_SU1: slot_reset = 8'hC0;
            SL_SU2:         slot_reset = 8'hCC;
            default:        slot_reset = 8'h00;
        endcase
    endfunction

    function automatic logic [2:0] setup_clocks(input logic [1:0] code);
        case (setup_code_e'(code))
            SU_TWO:   setup_clocks = 3'd2;
            SU_THREE: setup_clocks = 3'd3;
            SU_FOUR:  setup_clocks = 3'd4;
            default:  setup_clocks = 3'd5;
        endcase
    endfunction

    function automatic drv_timing_t unpack_timing(input logic [1:0] code,
                                                  input logic [REG_W-1:0] rw);
        drv_timing_t t;
        t.setup    = setup_clocks(code);
        t.active   = rw[7:4];
        t.recovery = rw[3:0];
        return t;
    endfunction

endpackage

// File: rtl/ide_tim_regfile.sv
module ide_tim_regfile
    import ide_tim_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  bank [NSLOT]
);

    always_ff @(posedge clk) begin
        for (int i = 0; i < NSLOT; i++) begin
            if (rst)
                bank[i] <= slot_reset(i);
            else if (reg_we && reg_addr == ADDR_W'(slot_offset(i)))
                bank[i] <= reg_wdata;
        end
    end

endmodule

// File: rtl/ide_tim_readmux.sv
module ide_tim_readmux
    import ide_tim_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int CHIP_REV = 2
) (
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  bank [NSLOT],
    input  logic              alt_base_strap,
    output logic [REG_W-1:0]  reg_rdata
);

    localparam logic [1:0] REV = CHIP_REV[1:0];

    logic [REG_W-1:0] cfg_byte;

    always_comb begin
        cfg_byte = '0;
        cfg_byte[1:0] = REV;
        cfg_byte[CFG_STRAP_BIT] = alt_base_strap;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(OFF_CFG))
            reg_rdata = cfg_byte;
        for (int i = 0; i < NSLOT; i++) begin
            if (reg_addr == ADDR_W'(slot_offset(i)))
                reg_rdata = bank[i];
        end
    end

endmodule

// File: rtl/ide_tim_select.sv
module ide_tim_select
    import ide_tim_pkg::*;
#(
    parameter int NSET = 3
) (
    input  logic [1:0]       su_code [NSET],
    input  logic [REG_W-1:0] rw_time [NSET],
    input  logic [1:0]       pri_ra_off,
    input  logic [1:0]       sec_ra_off,
    input  logic             sec_en,
    input  logic             sel_chan,
    input  logic             sel_drive,
    output drv_timing_t      cur,
    output logic             readahead_en
);

    localparam int SEL_W = $clog2(NSET);

    drv_timing_t      tset [NSET];
    logic [SEL_W-1:0] idx;

    for (genvar g = 0; g < NSET; g++) begin : g_set
        assign tset[g] = unpack_timing(su_code[g], rw_time[g]);
    end

    // primary drives own sets 0 and 1; both secondary drives share the last
    always_comb begin
        if (sel_chan)
            idx = SEL_W'(NSET - 1);
        else
            idx = SEL_W'(sel_drive);
    end

    assign cur = tset[idx];

    always_comb begin
        if (!sel_chan)
            readahead_en = ~pri_ra_off[sel_drive];
        else
            readahead_en = sec_en & ~sec_ra_off[sel_drive];
    end

endmodule

// File: rtl/ide_pio_timing_bank.sv
module ide_pio_timing_bank
    import ide_tim_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int CHIP_REV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              reg_we,
    output logic [7:0]        reg_rdata,
    input  logic              alt_base_strap,
    input  logic              sel_chan,
    input  logic              sel_drive,
    output logic [2:0]        setup_clks,
    output logic [3:0]        active_clks,
    output logic [3:0]        recovery_clks,
    output logic              readahead_en,
    output logic              sec_chan_en
);

    localparam int NSET = 3;

    logic [REG_W-1:0] bank [NSLOT];
    logic [1:0]       su_code [NSET];
    logic [REG_W-1:0] rw_time [NSET];
    drv_timing_t      cur;

    ide_tim_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .bank      (bank)
    );

    ide_tim_readmux #(.ADDR_W(ADDR_W), .CHIP_REV(CHIP_REV)) u_rd (
        .reg_addr       (reg_addr),
        .bank           (bank),
        .alt_base_strap (alt_base_strap),
        .reg_rdata      (reg_rdata)
    );

    assign su_code[0] = bank[SL_SU0][7:6];
    assign su_code[1] = bank[SL_SU1][7:6];
    assign su_code[2] = bank[SL_SU2][7:6];
    assign rw_time[0] = bank[SL_RW0];
    assign rw_time[1] = bank[SL_RW1];
    assign rw_time[2] = bank[SL_RW2];
    assign sec_chan_en = bank[SL_CTRL][CTRL_SEC_EN];

    ide_tim_select #(.NSET(NSET)) u_sel (
        .su_code      (su_code),
        .rw_time      (rw_time),
        .pri_ra_off   ({bank[SL_CTRL][CTRL_P1_RA_OFF], bank[SL_CTRL][CTRL_P0_RA_OFF]}),
        .sec_ra_off   ({bank[SL_SU2][SU2_S1_RA_OFF], bank[SL_SU2][SU2_S0_RA_OFF]}),
        .sec_en       (sec_chan_en),
        .sel_chan     (sel_chan),
        .sel_drive    (sel_drive),
        .cur          (cur),
        .readahead_en (readahead_en)
    );

    assign setup_clks    = cur.setup;
    assign active_clks   = cur.active;
    assign recovery_clks = cur.recovery;

endmodule

// File: rtl/ide_pio_timing_bank_chk.sv
module ide_pio_timing_bank_chk #(
    parameter int ADDR_W   = 8,
    parameter int CHIP_REV = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [7:0]        reg_wdata,
    input logic              reg_we,
    input logic [7:0]        reg_rdata,
    input logic              alt_base_strap,
    input logic              sel_chan,
    input logic [2:0]        setup_clks,
    input logic              readahead_en,
    input logic              sec_chan_en
);

    localparam logic [1:0] REV = CHIP_REV[1:0];

    logic addr_known;
    assign addr_known = (reg_addr >= ADDR_W'(8'h50) && reg_addr <= ADDR_W'(8'h58))
                     || (reg_addr == ADDR_W'(8'h5B));

    assert_setup_range_R3: assert property (@(posedge clk) disable iff (rst)
        setup_clks >= 3'd2 && setup_clks <= 3'd5);

    assert_sec_off_no_ra_R7: assert property (@(posedge clk) disable iff (rst)
        (sel_chan && !sec_chan_en) |-> !readahead_en);

    assert_scratch_echo_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == ADDR_W'(8'h5B)) ##1 (reg_addr == ADDR_W'(8'h5B))
        |-> reg_rdata == $past(reg_wdata));

    assert_cfg_byte_R9: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_W'(8'h50)) |->
        (reg_rdata[1:0] == REV && reg_rdata[1:0] != 2'b00
         && reg_rdata[5] == alt_base_strap && reg_rdata[7:6] == 2'b00
         && reg_rdata[4:2] == 3'b000));

    assert_unimpl_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !addr_known |-> reg_rdata == 8'h00);

    assert_reset_state_R2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!sec_chan_en
                        && (reg_addr != ADDR_W'(8'h57) || reg_rdata == 8'hCC)));

endmodule

bind ide_pio_timing_bank ide_pio_timing_bank_chk #(
    .ADDR_W(ADDR_W), .CHIP_REV(CHIP_REV)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .reg_addr       (reg_addr),
    .reg_wdata      (reg_wdata),
    .reg_we         (reg_we),
    .reg_rdata      (reg_rdata),
    .alt_base_strap (alt_base_strap),
    .sel_chan       (sel_chan),
    .setup_clks     (setup_clks),
    .readahead_en   (readahead_en),
    .sec_chan_en    (sec_chan_en)
);

// File: tb/ide_pio_timing_bank_bench.sv
module ide_pio_timing_bank_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic       reg_we = 1'b0;
    logic [7:0] reg_rdata;
    logic       alt_base_strap = 1'b0;
    logic       sel_chan = 1'b0;
    logic       sel_drive = 1'b0;
    logic [2:0] setup_clks;
    logic [3:0] active_clks;
    logic [3:0] recovery_clks;
    logic       readahead_en;
    logic       sec_chan_en;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  ended = 1'b0;

    always #4 clk = ~clk;

    ide_pio_timing_bank u_ide_pio_timing_bank (
        .clk            (clk),
        .rst            (rst),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .reg_we         (reg_we),
        .reg_rdata      (reg_rdata),
        .alt_base_strap (alt_base_strap),
        .sel_chan       (sel_chan),
        .sel_drive      (sel_drive),
        .setup_clks     (setup_clks),
        .active_clks    (active_clks),
        .recovery_clks  (recovery_clks),
        .readahead_en   (readahead_en),
        .sec_chan_en    (sec_chan_en)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic sel(input logic c, input logic dr);
        sel_chan = c; sel_drive = dr;
        #1;
    endtask

    function automatic int exp_setup(input logic [1:0] code);
        case (code)
            2'b01:   return 2;
            2'b10:   return 3;
            2'b00:   return 4;
            default: return 5;
        endcase
    endfunction

    task automatic t_reset;
        logic [7:0] v;
        rd(8'h53, v); check("R2 su0 reset", v, 8'hC0);
        rd(8'h55, v); check("R2 su1 reset", v, 8'hC0);
        rd(8'h57, v); check("R2 su2 reset", v, 8'hCC);
        rd(8'h51, v); check("R2 ctrl reset", v, 8'h00);
        rd(8'h52, v); check("R2 cmdt reset", v, 8'h00);
        rd(8'h54, v); check("R2 rw0 reset", v, 8'h00);
        rd(8'h56, v); check("R2 rw1 reset", v, 8'h00);
        rd(8'h58, v); check("R2 rw2 reset", v, 8'h00);
        rd(8'h5B, v); check("R2 scratch reset", v, 8'h00);
        check("R2 sec_chan_en reset", sec_chan_en, 0);
        sel(1'b0, 1'b0);
        check("R2 R3 reset setup 5 clocks", setup_clks, 5);
        check("R5 reset primary readahead on", readahead_en, 1);
    endtask

    task automatic t_rw;
        logic [7:0] v;
        for (int a = 8'h51; a <= 8'h58; a++) begin
            wr(8'(a), 8'(8'hA5 ^ a));
            rd(8'(a), v); check("R1 readback pattern A", v, (8'hA5 ^ a) & 8'hFF);
            wr(8'(a), 8'(8'h5A ^ a));
            rd(8'(a), v); check("R1 readback pattern B", v, (8'h5A ^ a) & 8'hFF);
        end
    endtask

    task automatic t_setup_decode;
        for (int c = 0; c < 4; c++) begin
            wr(8'h53, 8'((c << 6) | 8'h15));
            sel(1'b0, 1'b0);
            check("R3 setup code decode", setup_clks, exp_setup(2'(c)));
        end
    endtask

    task automatic t_timing_sel;
        wr(8'h53, 8'h40); wr(8'h54, 8'h3A);
        wr(8'h55, 8'h80); wr(8'h56, 8'h7C);
        wr(8'h57, 8'h00); wr(8'h58, 8'hE1);
        sel(1'b0, 1'b0);
        check("R4 p0 setup", setup_clks, 2);
        check("R4 p0 active", active_clks, 3);
        check("R4 p0 recovery", recovery_clks, 10);
        sel(1'b0, 1'b1);
        check("R4 p1 setup", setup_clks, 3);
        check("R4 p1 active", active_clks, 7);
        check("R4 p1 recovery", recovery_clks, 12);
        sel(1'b1, 1'b0);
        check("R4 s0 setup", setup_clks, 4);
        check("R4 s0 active", active_clks, 14);
        check("R4 s0 recovery", recovery_clks, 1);
        sel(1'b1, 1'b1);
        check("R4 s1 shares set", {setup_clks, active_clks, recovery_clks},
              {3'd4, 4'd14, 4'd1});
        wr(8'h57, 8'hC8);
        check("R4 R3 shared setup code 11", setup_clks, 5);
    endtask

    task automatic t_pri_ra;
        wr(8'h51, 8'h40);
        sel(1'b0, 1'b0); check("R5 bit6 gates drive0", readahead_en, 0);
        sel(1'b0, 1'b1); check("R5 bit6 leaves drive1", readahead_en, 1);
        wr(8'h51, 8'h80);
        sel(1'b0, 1'b0); check("R5 bit7 leaves drive0", readahead_en, 1);
        sel(1'b0, 1'b1); check("R5 bit7 gates drive1", readahead_en, 0);
    endtask

    task automatic t_sec_ra;
        wr(8'h51, 8'h08);
        check("R6 sec_chan_en from bit3", sec_chan_en, 1);
        wr(8'h57, 8'h00);
        sel(1'b1, 1'b0); check("R6 s0 enabled", readahead_en, 1);
        sel(1'b1, 1'b1); check("R6 s1 enabled", readahead_en, 1);
        wr(8'h57, 8'h04);
        sel(1'b1, 1'b0); check("R6 bit2 gates s0", readahead_en, 0);
        sel(1'b1, 1'b1); check("R6 bit2 leaves s1", readahead_en, 1);
        wr(8'h57, 8'h08);
        sel(1'b1, 1'b0); check("R6 bit3 leaves s0", readahead_en, 1);
        sel(1'b1, 1'b1); check("R6 bit3 gates s1", readahead_en, 0);
    endtask

    task automatic t_sec_off;
        wr(8'h51, 8'h00);
        wr(8'h57, 8'h00);
        check("R7 sec_chan_en clear", sec_chan_en, 0);
        sel(1'b1, 1'b0); check("R7 s0 forced low", readahead_en, 0);
        sel(1'b1, 1'b1); check("R7 s1 forced low", readahead_en, 0);
        sel(1'b0, 1'b1); check("R7 primary unaffected", readahead_en, 1);
    endtask

    task automatic t_scratch;
        logic [7:0] v;
        wr(8'h5B, 8'hBD); rd(8'h5B, v); check("R8 scratch BD", v, 8'hBD);
        wr(8'h5B, 8'h42); rd(8'h5B, v); check("R8 scratch 42", v, 8'h42);
    endtask

    task automatic t_cfg;
        logic [7:0] v;
        alt_base_strap = 1'b0;
        rd(8'h50, v); check("R9 cfg strap low", v, 8'h02);
        alt_base_strap = 1'b1;
        rd(8'h50, v); check("R9 cfg strap high", v, 8'h22);
        wr(8'h50, 8'hFF);
        rd(8'h50, v); check("R9 cfg write ignored", v, 8'h22);
    endtask

    task automatic t_unimpl;
        logic [7:0] snap [8'h51:8'h5B];
        logic [7:0] v;
        logic [10:0] outs;
        logic [7:0] holes [6] = '{8'h00, 8'h4F, 8'h59, 8'h5A, 8'h5C, 8'hFF};
        wr(8'h51, 8'h48); wr(8'h53, 8'h80); wr(8'h54, 8'h96);
        sel(1'b0, 1'b0);
        outs = {setup_clks, active_clks, recovery_clks};
        for (int a = 8'h51; a <= 8'h5B; a++) begin
            rd(8'(a), v); snap[a] = v;
        end
        for (int k = 0; k < 6; k++) wr(holes[k], 8'hFF);
        for (int k = 0; k < 6; k++) begin
            rd(holes[k], v); check("R10 hole reads zero", v, 0);
        end
        for (int a = 8'h51; a <= 8'h5B; a++) begin
            rd(8'(a), v); check("R10 register unchanged", v, snap[a]);
        end
        sel(1'b0, 1'b0);
        check("R10 outputs unchanged", {setup_clks, active_clks, recovery_clks}, outs);
        check("R10 readahead unchanged", readahead_en, 0);
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_rw();
        t_setup_decode();
        t_timing_sel();
        t_pri_ra();
        t_sec_ra();
        t_sec_off();
        t_scratch();
        t_cfg();
        t_unimpl();
        finish_run();
    end

endmodule